// File: doc/BRIEF.md
# Peak-Current PWM Cycle Controller

This block shapes the gate-on pulse of every switching cycle in a peak-current-mode converter. A one-clock strobe opens a cycle and turns the gate on unless a fault-disable input is high. From then on the block watches a sampled current-sense code every clock. Before it is compared, the code gets a ramp that starts at zero with each turn-on and grows by a fixed step per clock. The turn-off level is the lower of two sampled error codes, one from the voltage loop and one from the current loop. Whichever loop is not in control normally sits saturated high.

Four more rules override that comparison. A fixed absolute current limit cuts the pulse whenever the raw sense code goes above it. A blanking window right after turn-on hides both comparisons, so a turn-on spike cannot end the pulse. A minimum on-time holds the gate on even when a trip arrives early; the trip is remembered and takes effect once the minimum is reached. A maximum-duty clamp forces the gate off after a fixed share of the nominal cycle length. Once off, the gate stays off until the next strobe. A registered reason code records why the last pulse ended.

All inputs are plain sampled codes that update every clock. No data stream crosses this block's edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `pcm_peak_ctrl`

## Requirements
- R1: The gate rises only on a clock edge that samples `cyc_start`=1 with `fault_off`=0. An edge that samples `cyc_start`=1 with `fault_off`=1 leaves the gate low. Every strobe restarts on-time counting and clears `off_cause` to 0, and `off_cause` stays 0 while the gate is on.
- R2: Let k be the number of clock edges evaluated since the turn-on edge, with k=0 at the first of them. At edge k the loop trips when `isense` + RAMP_STEP·k >= min(`err_v`, `err_i`). A loop turn-off sets `off_cause`=1.
- R3: The current limit trips when the raw `isense` is strictly greater than ILIM_CODE (default 205). It sets `off_cause`=2 and wins over a loop trip found at the same edge.
- R4: Both trips are ignored at every edge with k < BLANK_CYC (default 4).
- R5: A trip found at an edge where k+1 < MIN_ON_CYC (default 8) is held, and the gate falls at the edge where k+1 = MIN_ON_CYC, with the cause of the first trip held. When the gate falls at edge k, it has been high for k+1 clocks.
- R6: The gate is never high for more than MAX_ON = PERIOD_CYC·DUTY_PCT/100 clocks (default 30). If no trip ends the pulse, it falls at k+1 = MAX_ON with `off_cause`=3.
- R7: After the gate falls, it stays low until an edge samples `cyc_start`=1, and `off_cause` keeps its value over that interval.
- R8: During and right after reset, `gate_on`=0 and `off_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | One-clock strobe that opens a switching cycle |
| fault_off | input | 1 | Blocks turn-on at a strobe while high |
| isense | input | CODE_W | Sampled current-sense code |
| err_v | input | CODE_W | Voltage-loop error code |
| err_i | input | CODE_W | Current-loop error code |
| gate_on | output | 1 | Gate enable, registered |
| off_cause | output | 2 | Reason for last turn-off: 0 none, 1 loop, 2 current limit, 3 max duty |

## Verification
The bench sets a trip exactly on the loop level, one code above it, and exactly at and just above the current-limit code. A design with `>` and `>=` swapped, or with the ramp offset by one clock, gives pulses one clock off. Separate stimuli place a sense spike inside the blanking window and a short spike between blanking and the minimum on-time. A design that skips blanking ends the first pulse early. One that drops the held trip runs the second pulse on to the duty clamp. Other tests check the limit-versus-loop priority, the lower of the two error codes, and a strobe taken while fault is high. A wrong priority reports the wrong reason code; a wrong code choice or an ignored fault input changes the pulse length.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [1:0] {
    CUT_NONE = 2'd0,
    CUT_LOOP = 2'd1,
    CUT_ILIM = 2'd2,
    CUT_MAXD = 2'd3
  } cut_cause_e;

endpackage

// File: rtl/pcm_ontimer.sv
module pcm_ontimer #(
  parameter int MAX_ON     = 30,
  parameter int BLANK_CYC  = 4,
  parameter int MIN_ON_CYC = 8,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic             unblanked,
  output logic             min_met,
  output logic             duty_hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (running && (int'(cnt) < MAX_ON)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    unblanked = (int'(cnt) >= BLANK_CYC);
    min_met   = (int'(cnt) + 1 >= MIN_ON_CYC);
    duty_hit  = (int'(cnt) + 1 >= MAX_ON);
  end

endmodule

// File: rtl/pcm_trip.sv
module pcm_trip #(
  parameter int CODE_W    = 10,
  parameter int CNT_W     = 5,
  parameter int RAMP_STEP = 4,
  parameter int ILIM_CODE = 205
) (
  input  logic [CODE_W-1:0] isense,
  input  logic [CODE_W-1:0] err_v,
  input  logic [CODE_W-1:0] err_i,
  input  logic [CNT_W-1:0]  cnt,
  output logic              loop_trip,
  output logic              ilim_trip
);

  localparam int RS_W  = (RAMP_STEP > 0) ? $clog2(RAMP_STEP + 1) : 1;
  localparam int SUM_W = CODE_W + CNT_W + RS_W + 1;
  localparam logic [CODE_W-1:0] ILIM_C = CODE_W'(ILIM_CODE);

  logic [CODE_W-1:0] level;
  logic [SUM_W-1:0]  ramp;
  logic [SUM_W-1:0]  sensed;

  always_comb begin
    level = (err_v < err_i) ? err_v : err_i;
  end

  generate
    if (RAMP_STEP > 0) begin : g_ramp
      always_comb ramp = SUM_W'(RAMP_STEP) * SUM_W'(cnt);
    end else begin : g_flat
      always_comb ramp = '0;
    end
  endgenerate

  always_comb begin
    sensed    = SUM_W'(isense) + ramp;
    loop_trip = (sensed >= SUM_W'(level));
    ilim_trip = (isense > ILIM_C);
  end

endmodule

// File: rtl/pcm_gate_ctrl.sv
module pcm_gate_ctrl
  import pcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fault,
  input  logic       unblanked,
  input  logic       min_met,
  input  logic       duty_hit,
  input  logic       loop_trip,
  input  logic       ilim_trip,
  output logic       gate,
  output cut_cause_e cause
);

  cut_cause_e pend;
  cut_cause_e fresh;
  cut_cause_e eff;

  always_comb begin
    fresh = CUT_NONE;
    if (unblanked) begin
      if (ilim_trip)      fresh = CUT_ILIM;
      else if (loop_trip) fresh = CUT_LOOP;
    end
    eff = (pend != CUT_NONE) ? pend : fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate  <= 1'b0;
      cause <= CUT_NONE;
      pend  <= CUT_NONE;
    end else if (start) begin
      gate  <= !fault;
      cause <= CUT_NONE;
      pend  <= CUT_NONE;
    end else if (gate) begin
      if ((eff != CUT_NONE) && min_met) begin
        gate  <= 1'b0;
        cause <= eff;
        pend  <= CUT_NONE;
      end else if (duty_hit) begin
        gate  <= 1'b0;
        cause <= CUT_MAXD;
        pend  <= CUT_NONE;
      end else begin
        pend  <= eff;
      end
    end
  end

endmodule

// File: rtl/pcm_peak_ctrl.sv
module pcm_peak_ctrl #(
  parameter int CODE_W     = 10,
  parameter int PERIOD_CYC = 40,
  parameter int DUTY_PCT   = 75,
  parameter int BLANK_CYC  = 4,
  parameter int MIN_ON_CYC = 8,
  parameter int RAMP_STEP  = 4,
  parameter int ILIM_CODE  = 205
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              fault_off,
  input  logic [CODE_W-1:0] isense,
  input  logic [CODE_W-1:0] err_v,
  input  logic [CODE_W-1:0] err_i,
  output logic              gate_on,
  output logic [1:0]        off_cause
);

  localparam int MAX_ON = PERIOD_CYC * DUTY_PCT / 100;
  localparam int CNT_W  = $clog2(MAX_ON + 1);

  logic [CNT_W-1:0]    cnt;
  logic                unblanked;
  logic                min_met;
  logic                duty_hit;
  logic                loop_trip;
  logic                ilim_trip;
  pcm_pkg::cut_cause_e cause;

  pcm_ontimer #(
    .MAX_ON(MAX_ON), .BLANK_CYC(BLANK_CYC), .MIN_ON_CYC(MIN_ON_CYC), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(cyc_start), .running(gate_on),
    .cnt(cnt), .unblanked(unblanked), .min_met(min_met), .duty_hit(duty_hit)
  );

  pcm_trip #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .RAMP_STEP(RAMP_STEP), .ILIM_CODE(ILIM_CODE)
  ) u_trip (
    .isense(isense), .err_v(err_v), .err_i(err_i), .cnt(cnt),
    .loop_trip(loop_trip), .ilim_trip(ilim_trip)
  );

  pcm_gate_ctrl u_gate (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .fault(fault_off),
    .unblanked(unblanked), .min_met(min_met), .duty_hit(duty_hit),
    .loop_trip(loop_trip), .ilim_trip(ilim_trip),
    .gate(gate_on), .cause(cause)
  );

  assign off_cause = cause;

endmodule

// File: rtl/pcm_peak_ctrl_chk.sv
module pcm_peak_ctrl_chk #(
  parameter int CODE_W     = 10,
  parameter int MAX_ON     = 30,
  parameter int BLANK_CYC  = 4,
  parameter int MIN_ON_CYC = 8,
  parameter int ILIM_CODE  = 205
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              fault_off,
  input logic [CODE_W-1:0] isense,
  input logic              gate_on,
  input logic [1:0]        off_cause
);

  localparam int RUN_W = $clog2(MAX_ON + 2) + 1;
  localparam logic [CODE_W-1:0] ILIM_C = CODE_W'(ILIM_CODE);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run <= '0;
    else if (cyc_start)          run <= RUN_W'(1);
    else if (gate_on) begin
      if (int'(run) <= MAX_ON)   run <= run + 1'b1;
    end else                     run <= '0;
  end

  p_rise_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(cyc_start && !fault_off));

  p_cause_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> (off_cause == 2'd0));

  p_ilim_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !cyc_start && (isense > ILIM_C) && (int'(run) >= MIN_ON_CYC)
     && (int'(run) > BLANK_CYC)) |=> !gate_on);

  p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !cyc_start && (int'(run) <= BLANK_CYC) && (int'(run) < MAX_ON)) |=> gate_on);

  p_min_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_on) && (off_cause == 2'd1 || off_cause == 2'd2)) |-> (int'(run) > MIN_ON_CYC));

  p_max_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> (int'(run) <= MAX_ON));

  p_stay_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on && !cyc_start) |=> (!gate_on && $stable(off_cause)));

  p_reset_idle_r8: assert property (@(posedge clk)
    !rst_n |-> (!gate_on && off_cause == 2'd0));

endmodule

bind pcm_peak_ctrl pcm_peak_ctrl_chk #(
  .CODE_W(CODE_W), .MAX_ON(MAX_ON), .BLANK_CYC(BLANK_CYC),
  .MIN_ON_CYC(MIN_ON_CYC), .ILIM_CODE(ILIM_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fault_off(fault_off),
  .isense(isense), .gate_on(gate_on), .off_cause(off_cause)
);

// File: tb/pcm_peak_ctrl_tb.sv
module pcm_peak_ctrl_tb;

  localparam int CODE_W = 10;
  localparam int PERIOD = 40;
  localparam int MAXON  = 30;
  localparam int BLANK  = 4;
  localparam int MINON  = 8;
  localparam int RAMP   = 4;
  localparam int ILIM   = 205;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cyc_start = 1'b0;
  logic              fault_off = 1'b0;
  logic [CODE_W-1:0] isense = '0;
  logic [CODE_W-1:0] err_v = '1;
  logic [CODE_W-1:0] err_i = '1;
  logic              gate_on;
  logic [1:0]        off_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcm_peak_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fault_off(fault_off),
    .isense(isense), .err_v(err_v), .err_i(err_i),
    .gate_on(gate_on), .off_cause(off_cause)
  );

  // behavioural reference, updated on each clock edge
  int m_gate, m_k, m_cause, m_pend, m_fresh, m_eff, m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gate = 0; m_k = 0; m_cause = 0; m_pend = 0;
    end else if (cyc_start) begin
      m_gate = fault_off ? 0 : 1; m_k = 0; m_cause = 0; m_pend = 0;
    end else if (m_gate != 0) begin
      m_fresh = 0;
      m_lvl = (int'(err_v) < int'(err_i)) ? int'(err_v) : int'(err_i);
      if (m_k >= BLANK) begin
        if (int'(isense) > ILIM) m_fresh = 2;
        else if (int'(isense) + RAMP * m_k >= m_lvl) m_fresh = 1;
      end
      m_eff = (m_pend != 0) ? m_pend : m_fresh;
      if (m_eff != 0 && m_k + 1 >= MINON) begin
        m_gate = 0; m_cause = m_eff; m_pend = 0;
      end else if (m_k + 1 >= MAXON) begin
        m_gate = 0; m_cause = 3; m_pend = 0;
      end else begin
        m_pend = m_eff; m_k = m_k + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!done) begin
        check("model gate_on", int'(gate_on), m_gate);
        check("model off_cause", int'(off_cause), m_cause);
      end
    end
  end

  // one switching cycle: strobe, then PERIOD clocks of sense codes
  task automatic pulse(input int iv, input int ev, input int ei, input int flt,
                       input int spk, input int klo, input int khi,
                       output int len, output int cz, output int rerise,
                       output int cz_on);
    bit fell;
    len = 0; rerise = 0; fell = 1'b0; cz_on = 0;
    @(negedge clk);
    cyc_start = 1'b1; fault_off = flt[0];
    err_v = CODE_W'(ev); err_i = CODE_W'(ei); isense = CODE_W'(iv);
    for (int t = 0; t < PERIOD; t++) begin
      @(negedge clk);
      cyc_start = 1'b0; fault_off = 1'b0;
      if (t == 0) cz_on = int'(off_cause);
      if (gate_on) begin
        if (fell) rerise++;
        else len++;
      end else if (len > 0) fell = 1'b1;
      isense = CODE_W'((t >= klo && t <= khi) ? spk : iv);
    end
    cz = int'(off_cause);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int len, cz, rr, czo;
    repeat (3) @(negedge clk);
    check("R8 reset gate_on", int'(gate_on), 0);
    check("R8 reset off_cause", int'(off_cause), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset gate_on", int'(gate_on), 0);

    // loop on err_v: 100+4k>=200 at k=25 -> 26 clocks
    pulse(100, 200, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R2 loop length", len, 26);
    check("R2 loop cause", cz, 1);
    check("R1 cause cleared at turn-on", czo, 0);
    check("R7 no re-rise", rr, 0);
    // one code above: k=26 -> 27 clocks
    pulse(100, 201, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R2 level+1 length", len, 27);
    // err_i lower: 100+4k>=160 at k=15 -> 16 clocks
    pulse(100, 1023, 160, 0, 0, -1, -1, len, cz, rr, czo);
    check("R2 min code length", len, 16);
    check("R2 min code cause", cz, 1);
    // no trip: duty clamp
    pulse(0, 1023, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R6 max duty length", len, MAXON);
    check("R6 max duty cause", cz, 3);
    check("R7 off holds to period end", rr, 0);
    // limit boundary
    pulse(205, 1023, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R3 at limit code length", len, MAXON);
    check("R3 at limit code cause", cz, 3);
    pulse(206, 1023, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R3 above limit length", len, MINON);
    check("R3 above limit cause", cz, 2);
    // limit and loop together: limit wins
    pulse(300, 250, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R3 priority cause", cz, 2);
    // spike only inside blanking
    pulse(0, 1023, 1023, 0, 300, 0, BLANK - 1, len, cz, rr, czo);
    check("R4 blanked spike length", len, MAXON);
    check("R4 blanked spike cause", cz, 3);
    // short spike after blanking, before minimum on-time
    pulse(0, 1023, 1023, 0, 300, 5, 5, len, cz, rr, czo);
    check("R5 held trip length", len, MINON);
    check("R5 held trip cause", cz, 2);
    // loop trip present from k=0, first seen at k=BLANK, released at min on
    pulse(100, 100, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R5 early loop length", len, MINON);
    check("R5 early loop cause", cz, 1);
    // strobe with fault high
    pulse(0, 1023, 1023, 1, 0, -1, -1, len, cz, rr, czo);
    check("R1 fault blocks turn-on", len, 0);
    check("R1 fault clears cause", cz, 0);
    // normal pulse after the fault
    pulse(100, 200, 1023, 0, 0, -1, -1, len, cz, rr, czo);
    check("R1 turn-on after fault", len, 26);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule